// File: doc/BRIEF.md
# Presence-Detect Serial Store Slave

This block is a two-wire serial bus slave that stores 256 bytes describing a memory module. A host controller reads identification and timing bytes from it, and may keep its own notes in the upper part of the store. The block runs from a fast system clock and oversamples the serial clock and data lines. It pulls the data line low through an open-drain enable and never drives it high.

The lower 128 bytes are filled once through a parallel preload port after reset and are read-only from the bus. The upper 128 bytes start at zero and can be written from the bus unless the write-lock input is high. Three strap inputs form the low bits of the bus address, so up to eight such stores can share one bus. An internal byte pointer supports byte and multi-byte writes, random reads (a write of the word address followed by a repeated START) and sequential or current-address reads.

Top module: `spd_store_slave`

## Requirements
- R1: After reset the data line is released (`sda_pull`=0), the upper 128 bytes read as 0x00 and the byte pointer is 0, so a current-address read returns byte 0.
- R2: A frame whose first byte carries the 7-bit address 1010 followed by `strap[2:0]` (bit 0 of that byte: 1 = read, 0 = write) is acknowledged by holding SDA low during the 9th clock. Any other address is not acknowledged, and the slave leaves SDA released until the next START.
- R3: In a write frame the second byte sets the pointer. Each further byte is stored at the pointer, acknowledged, and the pointer then increments.
- R4: A data byte aimed at a location whose address bit 7 is 0 (bytes 0 to 127) is acknowledged but leaves the store unchanged.
- R5: While `wr_lock` is 1, data bytes are acknowledged but the store is unchanged.
- R6: A read frame returns the byte at the pointer, most significant bit first, and increments the pointer. Further bytes follow while the master acknowledges (SDA low in the 9th clock).
- R7: The pointer wraps from 255 to 0 on both reads and writes.
- R8: A read frame with no preceding word address continues from the pointer left by the last access.
- R9: After a master not-acknowledge the slave releases SDA and keeps it released until START, so the master can issue STOP.
- R10: The slave asserts `sda_pull` only while SCL is low. START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) release SDA.
- R11: A pulse on `preload_en` writes `preload_data` into byte `preload_addr` of the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial bus clock level |
| sda_in | input | 1 | Serial bus data level (wired line) |
| sda_pull | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Low three bits of the bus address |
| wr_lock | input | 1 | 1 blocks all bus writes |
| preload_en | input | 1 | Write strobe for the lower half |
| preload_addr | input | 7 | Byte index within the lower half |
| preload_data | input | 8 | Byte to preload |

## Verification
A wrong pointer shows up at the ports on the next read byte: every later byte comes back shifted, or from the wrong half after a wrap. A wrong protocol state shows up within one byte time as a missing or spurious acknowledge, or as SDA held low when the master expects to drive it. The bench's reads check that no write reached the read-only half, the locked half or a store with a different address. Writes are checked through the bytes returned by reads.

// File: rtl/spd_pkg.sv
// Shared constants and types for the presence-detect serial store.
// Assumes 8-bit bus bytes and an 8-bit word pointer.
package spd_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int STRAP_W = 3;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RD, ST_RACK, ST_IGNORE
    } proto_state_t;

    // True when the received 7-bit address matches the prefix plus straps.
    function automatic logic dev_match(input logic [6:0] a,
                                       input logic [STRAP_W-1:0] s);
        return a == {DEV_PREFIX, s};
    endfunction
endpackage

// File: rtl/spd_line_sync.sv
// Synchronises one bus line into clk and flags its edges.
// Assumes the line idles high and holds each level for several clk cycles.
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the raw line through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], line_in};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
    assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/spd_store.sv
// Byte store: lower half loaded by the preload port, any byte by the bus side.
// Assumes the caller already restricts bus writes to the allowed region.
module spd_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_en,
    input  logic [AW-2:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    // Clear on reset; accept preload and bus writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            if (pre_en) cells[{1'b0, pre_addr}] <= pre_data;
            if (we)     cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spd_proto.sv
// Bus protocol engine: address match, acknowledge, pointer and byte shifting.
// Assumes edge flags from synchronised lines; SCL low lasts several clk cycles.
module spd_proto
    import spd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_lock,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               pull,
    output logic               mem_we,
    output logic [PTR_W-1:0]   mem_waddr,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic [PTR_W-1:0]   ptr,
    output logic               ptr_step,
    output logic               ignoring
);
    proto_state_t      state;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bitcnt;
    logic              got;
    logic              rw;
    logic              mack;

    // Walk the bus frame one SCL edge at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            got       <= 1'b0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            pull      <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            ptr       <= '0;
            ptr_step  <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            ptr_step <= 1'b0;
            if (start_evt) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                got    <= 1'b0;
                pull   <= 1'b0;
            end else if (stop_evt) begin
                state <= ST_IDLE;
                got   <= 1'b0;
                pull  <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got <= 1'b1;
                        end else if (scl_fall && got) begin
                            got    <= 1'b0;
                            bitcnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_match(shreg[7:1], strap)) begin
                                    pull  <= 1'b1;
                                    rw    <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_WORD) begin
                                ptr   <= shreg;
                                pull  <= 1'b1;
                                state <= ST_WORD_ACK;
                            end else begin
                                mem_we    <= ptr[PTR_W-1] && !wr_lock;
                                mem_waddr <= ptr;
                                mem_wdata <= shreg;
                                ptr       <= ptr + 1'b1;
                                ptr_step  <= 1'b1;
                                pull      <= 1'b1;
                                state     <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg    <= rd_data;
                                pull     <= ~rd_data[BYTE_W-1];
                                ptr      <= ptr + 1'b1;
                                ptr_step <= 1'b1;
                                bitcnt   <= '0;
                                state    <= ST_RD;
                            end else begin
                                pull  <= 1'b0;
                                state <= ST_WORD;
                            end
                        end
                    end
                    ST_WORD_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            pull  <= 1'b0;
                            state <= ST_WDATA;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                pull  <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                pull   <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg    <= rd_data;
                                pull     <= ~rd_data[BYTE_W-1];
                                ptr      <= ptr + 1'b1;
                                ptr_step <= 1'b1;
                                bitcnt   <= '0;
                                state    <= ST_RD;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ignoring = (state == ST_IGNORE);
endmodule

// File: rtl/spd_store_slave.sv
// Top: presence-detect serial store slave with strap address and write lock.
// Assumes clk runs at least 16 times faster than SCL.
module spd_store_slave
    import spd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_lock,
    input  logic               preload_en,
    input  logic [PTR_W-2:0]   preload_addr,
    input  logic [BYTE_W-1:0]  preload_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, lvl, rse, fal;
    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .line_in(raw[g]),
            .level(lvl[g]), .rise(rse[g]), .fall(fal[g])
        );
    end

    logic scl_lvl, start_evt, stop_evt;
    assign scl_lvl   = lvl[0];
    assign start_evt = fal[1] & lvl[0];
    assign stop_evt  = rse[1] & lvl[0];

    logic              mem_we, ptr_step, ignoring;
    logic [PTR_W-1:0]  mem_waddr, ptr_cur;
    logic [BYTE_W-1:0] mem_wdata, rd_data;

    spd_proto u_proto (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(rse[0]), .scl_fall(fal[0]), .sda_lvl(lvl[1]),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .strap(strap), .wr_lock(wr_lock), .rd_data(rd_data),
        .pull(sda_pull), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .ptr(ptr_cur), .ptr_step(ptr_step),
        .ignoring(ignoring)
    );

    spd_store #(.AW(PTR_W), .DW(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .pre_en(preload_en), .pre_addr(preload_addr), .pre_data(preload_data),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(ptr_cur), .rdata(rd_data)
    );
endmodule

// File: rtl/spd_store_chk.sv
// Checker for the serial store slave, bound into its top module.
module spd_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull,
    input logic       scl_lvl,
    input logic       stop_evt,
    input logic       ignoring,
    input logic       wr_lock,
    input logic       mem_we,
    input logic [7:0] mem_waddr,
    input logic [7:0] ptr_cur,
    input logic       ptr_step
);
    // R10
    pull_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull);
    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> !sda_pull);
    // R4
    lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_waddr[7]);
    // R5
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_lock));
    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_step |-> ptr_cur == 8'($past(ptr_cur) + 8'd1));
endmodule

bind spd_store_slave spd_store_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_lvl(scl_lvl),
    .stop_evt(stop_evt), .ignoring(ignoring), .wr_lock(wr_lock),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .ptr_cur(ptr_cur),
    .ptr_step(ptr_step)
);

// File: tb/spd_store_slave_test.sv
// Scoreboard bench: bus tasks push expected bytes/acks, a monitor compares.
module spd_store_slave_test;
    localparam int Q = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       scl_m = 1, sda_m = 1;
    logic       sda_pull;
    logic [2:0] strap = 3'b000;
    logic       wr_lock = 0;
    logic       preload_en = 0;
    logic [6:0] preload_addr = '0;
    logic [7:0] preload_data = '0;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    spd_store_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(strap), .wr_lock(wr_lock),
        .preload_en(preload_en), .preload_addr(preload_addr),
        .preload_data(preload_data)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mdl [256];
    logic [7:0] mptr = 0;
    logic [7:0] exp_q [$];
    string      req_q [$];
    logic [7:0] obs_q [$];

    function automatic logic [7:0] pre_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop an observed item, compare with the oldest expectation.
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            check(req_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic expect_item(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
    endtask

    task automatic bit_in(output logic v);
        sda_m = 1; qwait(); scl_m = 1; qwait(); v = sda_line; qwait(); scl_m = 0; qwait();
    endtask

    // Send a byte; the sampled acknowledge bit goes to the scoreboard.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack_bit, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        expect_item({7'd0, exp_ack_bit}, req);
        bit_in(a);
        obs_q.push_back({7'd0, a});
    endtask

    // Receive a byte and answer with ack (1) or not-ack (0).
    task automatic recv_byte(input logic ack, input string req);
        logic [7:0] d;
        logic v;
        expect_item(mdl[mptr], req);
        mptr = mptr + 1;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            d[i] = v;
        end
        obs_q.push_back(d);
        bit_out(~ack);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic write_bytes(input logic [7:0] word, input logic [7:0] d0,
                               input logic [7:0] d1, input int n, input string req);
        bus_start();
        send_byte(dev(0), 0, "R2");
        send_byte(word, 0, req);
        mptr = word;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = (i == 0) ? d0 : d1;
            send_byte(d, 0, req);
            if (mptr[7] && !wr_lock) mdl[mptr] = d;
            mptr = mptr + 1;
        end
        bus_stop();
    endtask

    task automatic read_bytes(input logic [7:0] word, input int n, input string req);
        bus_start();
        send_byte(dev(0), 0, "R2");
        send_byte(word, 0, "R6");
        mptr = word;
        bus_start();
        send_byte(dev(1), 0, "R2");
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, req);
        #1 check("R9", {7'd0, sda_pull}, 8'd0);
        bus_stop();
    endtask

    task automatic read_current(input int n, input string req);
        bus_start();
        send_byte(dev(1), 0, "R2");
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, req);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = (i < 128) ? pre_val(i) : 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1", {7'd0, sda_pull}, 8'd0);
        // R11: preload the lower half through the parallel port.
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            preload_en = 1; preload_addr = 7'(i); preload_data = pre_val(i);
        end
        @(negedge clk) preload_en = 0;
        qwait();

        // R1/R8: current-address read right after reset starts at byte 0.
        mptr = 0;
        read_current(2, "R1");
        // R11: preloaded bytes come back.
        read_bytes(8'h40, 3, "R11");
        // R3: two-byte write to the upper half, read back.
        write_bytes(8'h90, 8'hA5, 8'h5A, 2, "R3");
        read_bytes(8'h90, 2, "R3");
        check("R3", mdl[8'h91], 8'h5A);
        // R4: lower-half write acknowledged but ignored.
        write_bytes(8'h10, 8'hFF, 8'hFF, 1, "R4");
        read_bytes(8'h10, 1, "R4");
        // R5: lock blocks an upper-half write.
        wr_lock = 1;
        write_bytes(8'hA0, 8'h11, 8'h22, 2, "R5");
        wr_lock = 0;
        read_bytes(8'hA0, 2, "R5");
        // R7: write wraps 255 -> 0 (byte 0 protected), sequential read wraps.
        write_bytes(8'hFF, 8'h12, 8'h34, 2, "R7");
        read_bytes(8'hFE, 4, "R7");
        // R8: current-address read continues from the pointer.
        read_current(2, "R8");
        // R6: long sequential read across the half boundary.
        read_bytes(8'h7E, 4, "R6");
        // R2: other strap value, and a mismatched address is ignored.
        strap = 3'b101;
        write_bytes(8'hC0, 8'h77, 8'h00, 1, "R2");
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, 1, "R2");
        send_byte(8'hC0, 1, "R2");
        send_byte(8'h00, 1, "R2");
        bus_stop();
        strap = 3'b000;
        bus_start();
        send_byte({4'b1010, 3'b101, 1'b0}, 1, "R2");
        bus_stop();
        strap = 3'b101;
        read_bytes(8'hC0, 1, "R2");
        qwait();
        check("R10", {7'd0, sda_pull}, 8'd0);

        wait (obs_q.size() == 0);
        qwait();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule